// File: doc/BRIEF.md
# Sampled DC Offset Extractor Slicer

This block turns a stream of signed demodulator samples into hard bit decisions when the samples sit on an unknown DC level left by carrier frequency error. It keeps a slicer threshold and compares every incoming sample against it. It returns one decision per sample, together with the threshold that decision used.

The threshold is estimated in three phases. A single phase-control input, driven by the baseband, steps the block through them. While the control is low after a packet start, a running minimum and maximum give a fast, rough midpoint. A rising edge on the control loads that midpoint into a leaky integrator, which refines the estimate over the last part of the access code. A falling edge freezes the estimate, and from then on only a very slow correction follows carrier drift.

A mode input selects between two refinement profiles. With the mode low, the integrator runs at a medium rate for a fixed number of samples and then at a slow rate. With the mode high, it uses the slow rate from the first sample.

Top module: `dcx_slicer`

## Requirements
- R1: While reset is high and in the first cycle after it, `bit_valid` is 0 and `thr_out` is 0.
- R2: Each sample with `smp_valid` high gives `bit_valid` high exactly one cycle later. `bit_out` is 1 when the sample, read as signed two's complement, is greater than or equal to the threshold in effect in the sample's cycle, and `thr_out` reports that threshold. Without a sample, `bit_valid` is 0 in the next cycle.
- R3: `pkt_start` sets the minimum register to the largest and the maximum register to the smallest signed value, and returns the block to acquisition. It takes priority over every other input in its cycle, so a sample in that cycle is sliced but not used. A register is updated only by a strictly smaller (minimum) or strictly larger (maximum) sample. Until both registers have been updated at least once, the acquisition threshold is 0.
- R4: In acquisition, the threshold is (max + min) arithmetically shifted right by one, which rounds toward minus infinity.
- R5: On a rising edge of `phase_ctl`, the integrator is loaded with the current min/max midpoint and refinement starts. A sample in the edge cycle is not integrated and does not update min/max.
- R6: With `slow_only` = 0, the first 8 integrated samples of refinement use shift k = 3 and later samples use k = 6.
- R7: With `slow_only` = 1, refinement uses k = 6 from its first sample.
- R8: A falling edge of `phase_ctl` during refinement enters hold, where every integrated sample uses k = 10. A sample in the edge cycle is not integrated.
- R9: An integration step sets thr to thr + floor((x - thr) / 2^k), computed without overflow.
- R10: Outside acquisition, min and max stay unchanged. A later rising edge, including one in hold, reloads the integrator with that same frozen midpoint and restarts refinement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | One-cycle pulse at packet start; clears the extremes |
| phase_ctl | input | 1 | Phase control from the baseband; rising edge starts refinement, falling edge starts hold |
| slow_only | input | 1 | 0: medium then slow refinement; 1: slow only |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | W (12) | Signed demodulator sample |
| bit_valid | output | 1 | Decision strobe, one cycle after the sample |
| bit_out | output | 1 | Hard decision |
| thr_out | output | W (12) | Signed threshold used for the decision |

## Verification
Packets are built from a DC offset plus an alternating or run-length symbol pattern with small noise. Positive and negative offsets show whether the min/max midpoint and its floor rounding follow the true level. Sample gaps and edges placed on sample cycles separate the cases where a sample is integrated from those where it is only sliced. Running both modes with identical input tells the medium-then-slow profile apart from the slow-only one. A drifting offset in hold, a second rising edge in hold and a packet whose first sample is the largest positive value exercise the tracking, reseeding and "both extremes updated" corners.

// File: rtl/dcx_pkg.sv
package dcx_pkg;

    localparam int SHW = 5;

    typedef enum logic [1:0] {
        PH_ACQ    = 2'd0,
        PH_REFINE = 2'd1,
        PH_HOLD   = 2'd2
    } dcx_phase_e;

    typedef struct packed {
        dcx_phase_e       phase;
        logic             track;
        logic             seed;
        logic             integrate;
        logic [SHW-1:0]   shift;
    } dcx_ctl_t;

    function automatic logic [SHW-1:0] pick_shift(
        input dcx_phase_e ph,
        input logic       slow_only,
        input logic       in_medium,
        input int unsigned k_med,
        input int unsigned k_slow,
        input int unsigned k_hold
    );
        logic [SHW-1:0] k;
        if (ph == PH_HOLD)
            k = SHW'(k_hold);
        else if (!slow_only && in_medium)
            k = SHW'(k_med);
        else
            k = SHW'(k_slow);
        return k;
    endfunction

endpackage

// File: rtl/dcx_phase_ctrl.sv
module dcx_phase_ctrl
    import dcx_pkg::*;
#(
    parameter int unsigned K_MED   = 3,
    parameter int unsigned K_SLOW  = 6,
    parameter int unsigned K_HOLD  = 10,
    parameter int unsigned MED_LEN = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pkt_start,
    input  logic     phase_ctl,
    input  logic     slow_only,
    input  logic     smp_valid,
    output dcx_ctl_t ctl
);
    localparam int CW = $clog2(MED_LEN + 1);

    dcx_phase_e    phase_q;
    logic          ctl_q;
    logic [CW-1:0] med_cnt_q;
    logic          rise, fall, in_medium;

    assign rise      = phase_ctl & ~ctl_q;
    assign fall      = ~phase_ctl & ctl_q;
    assign in_medium = (phase_q == PH_REFINE) && (med_cnt_q < CW'(MED_LEN));

    always_comb begin
        ctl.phase     = phase_q;
        ctl.seed      = rise & ~pkt_start;
        ctl.track     = smp_valid & ~pkt_start & ~rise & (phase_q == PH_ACQ);
        ctl.integrate = smp_valid & ~pkt_start & ~rise & ~fall & (phase_q != PH_ACQ);
        ctl.shift     = pick_shift(phase_q, slow_only, in_medium, K_MED, K_SLOW, K_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_ACQ;
            ctl_q     <= 1'b0;
            med_cnt_q <= '0;
        end else begin
            ctl_q <= phase_ctl;
            if (pkt_start) begin
                phase_q   <= PH_ACQ;
                med_cnt_q <= '0;
            end else if (rise) begin
                phase_q   <= PH_REFINE;
                med_cnt_q <= '0;
            end else if (fall && phase_q == PH_REFINE) begin
                phase_q <= PH_HOLD;
            end else if (ctl.integrate && in_medium) begin
                med_cnt_q <= med_cnt_q + 1'b1;
            end
        end
    end

    a_r3_pkt_to_acq: assert property (@(posedge clk) disable iff (rst)
        pkt_start |=> phase_q == PH_ACQ);
    a_r8_fall_enters_hold: assert property (@(posedge clk) disable iff (rst)
        (fall && !pkt_start && phase_q == PH_REFINE) |=> phase_q == PH_HOLD);
    a_r5_rise_enters_refine: assert property (@(posedge clk) disable iff (rst)
        (rise && !pkt_start) |=> (phase_q == PH_REFINE && med_cnt_q == '0));
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        med_cnt_q <= CW'(MED_LEN));
endmodule

// File: rtl/dcx_minmax.sv
module dcx_minmax #(
    parameter int unsigned W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                track,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] mid,
    output logic                ready
);
    localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] mn_q, mx_q;
    logic                got_mn_q, got_mx_q;
    logic signed [W:0]   sum;

    assign sum   = {mx_q[W-1], mx_q} + {mn_q[W-1], mn_q};
    assign mid   = W'(sum >>> 1);
    assign ready = got_mn_q & got_mx_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mn_q     <= SMAX;
            mx_q     <= SMIN;
            got_mn_q <= 1'b0;
            got_mx_q <= 1'b0;
        end else if (track) begin
            if (x < mn_q) begin
                mn_q     <= x;
                got_mn_q <= 1'b1;
            end
            if (x > mx_q) begin
                mx_q     <= x;
                got_mx_q <= 1'b1;
            end
        end
    end

    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        ready |-> mn_q <= mx_q);
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (!track && !clr) |=> ($stable(mn_q) && $stable(mx_q)));
    a_r3_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ready);
endmodule

// File: rtl/dcx_integrator.sv
module dcx_integrator
    import dcx_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                seed,
    input  logic signed [W-1:0] seed_val,
    input  logic                integrate,
    input  logic [SHW-1:0]      shift,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] thr
);
    logic signed [W:0] diff, step;

    assign diff = {x[W-1], x} - {thr[W-1], thr};
    assign step = diff >>> shift;

    always_ff @(posedge clk) begin
        if (rst)
            thr <= '0;
        else if (seed)
            thr <= seed_val;
        else if (integrate)
            thr <= W'({thr[W-1], thr} + step);
    end

    a_r5_seed_loads: assert property (@(posedge clk) disable iff (rst)
        seed |=> thr == $past(seed_val));
    a_r9_moves_toward_x: assert property (@(posedge clk) disable iff (rst)
        (integrate && !seed && x >= thr) |=> (thr >= $past(thr) && thr <= $past(x)));
endmodule

// File: rtl/dcx_slicer.sv
module dcx_slicer
    import dcx_pkg::*;
#(
    parameter int unsigned W       = 12,
    parameter int unsigned K_MED   = 3,
    parameter int unsigned K_SLOW  = 6,
    parameter int unsigned K_HOLD  = 10,
    parameter int unsigned MED_LEN = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pkt_start,
    input  logic         phase_ctl,
    input  logic         slow_only,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    output logic         bit_valid,
    output logic         bit_out,
    output logic [W-1:0] thr_out
);
    dcx_ctl_t            ctl;
    logic signed [W-1:0] x, mid, thr_int, thr_eff;
    logic                mm_ready;

    assign x = $signed(smp_data);

    dcx_phase_ctrl #(
        .K_MED(K_MED), .K_SLOW(K_SLOW), .K_HOLD(K_HOLD), .MED_LEN(MED_LEN)
    ) u_ctrl (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .phase_ctl(phase_ctl),
        .slow_only(slow_only), .smp_valid(smp_valid), .ctl(ctl)
    );

    dcx_minmax #(.W(W)) u_minmax (
        .clk(clk), .rst(rst), .clr(pkt_start), .track(ctl.track),
        .x(x), .mid(mid), .ready(mm_ready)
    );

    dcx_integrator #(.W(W)) u_integ (
        .clk(clk), .rst(rst), .seed(ctl.seed), .seed_val(mid),
        .integrate(ctl.integrate), .shift(ctl.shift), .x(x), .thr(thr_int)
    );

    always_comb begin
        if (ctl.phase == PH_ACQ)
            thr_eff = mm_ready ? mid : '0;
        else
            thr_eff = thr_int;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
            thr_out   <= '0;
        end else begin
            bit_valid <= smp_valid;
            if (smp_valid) begin
                bit_out <= (x >= thr_eff);
                thr_out <= thr_eff;
            end
        end
    end

    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> bit_valid);
    a_r2_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !bit_valid);
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(thr_out) && $stable(bit_out)));
endmodule

// File: tb/dcx_slicer_bench.sv
module dcx_slicer_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pkt_start = 1'b0, phase_ctl = 1'b0, slow_only = 1'b0, smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         bit_valid, bit_out;
    logic [W-1:0] thr_out;

    always #4 clk = ~clk;

    dcx_slicer u_dcx_slicer (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .phase_ctl(phase_ctl),
        .slow_only(slow_only), .smp_valid(smp_valid), .smp_data(smp_data),
        .bit_valid(bit_valid), .bit_out(bit_out), .thr_out(thr_out)
    );

    int errors = 0, checks = 0, cycles = 0;

    // reference model state
    int    m_mn, m_mx, m_thr, m_ph, m_cnt, m_ctlq;
    bit    m_gmn, m_gmx;
    bit    e_bv, e_bit;
    int    e_thr;
    string e_tag;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic model_reset();
        m_mn = 2047; m_mx = -2048; m_gmn = 0; m_gmx = 0;
        m_thr = 0; m_ph = 0; m_cnt = 0; m_ctlq = 0;
        e_bv = 0; e_bit = 0; e_thr = 0; e_tag = "R1";
    endtask

    // one model step using the inputs presently driven
    task automatic model_step();
        int x, thr_now, k;
        bit rise, fall;
        x       = $signed(smp_data);
        rise    = phase_ctl && !m_ctlq;
        fall    = !phase_ctl && m_ctlq;
        thr_now = (m_ph == 0) ? ((m_gmn && m_gmx) ? ((m_mx + m_mn) >>> 1) : 0) : m_thr;
        if (m_ph == 0) e_tag = (m_gmn && m_gmx) ? "R4" : "R3";
        else if (m_ph == 2) e_tag = "R8 R9";
        else e_tag = slow_only ? "R7 R9" : "R6 R9";
        e_bv = smp_valid;
        if (smp_valid) begin
            e_bit = (x >= thr_now);
            e_thr = thr_now;
        end
        if (m_ph == 2) k = 10;
        else if (!slow_only && m_cnt < 8) k = 3;
        else k = 6;
        if (pkt_start) begin
            m_mn = 2047; m_mx = -2048; m_gmn = 0; m_gmx = 0;
            m_ph = 0; m_cnt = 0;
        end else if (rise) begin
            m_thr = (m_mx + m_mn) >>> 1;
            m_ph = 1; m_cnt = 0;
        end else if (smp_valid && m_ph == 0) begin
            if (x < m_mn) begin m_mn = x; m_gmn = 1; end
            if (x > m_mx) begin m_mx = x; m_gmx = 1; end
        end else if (fall) begin
            if (m_ph == 1) m_ph = 2;
        end else if (smp_valid) begin
            m_thr = m_thr + ((x - m_thr) >>> k);
            if (m_ph == 1 && m_cnt < 8) m_cnt++;
        end
        m_ctlq = phase_ctl;
    endtask

    task automatic compare(input string extra);
        chk("R2 strobe", int'(bit_valid), int'(e_bv));
        if (e_bv) begin
            chk({e_tag, extra, " threshold"}, $signed(thr_out), e_thr);
            chk({"R2 ", e_tag, extra, " decision"}, int'(bit_out), int'(e_bit));
        end
    endtask

    string note = "";

    task automatic cyc(input bit v, input int x, input bit ctl, input bit pk);
        @(negedge clk);
        compare(note);
        note = "";
        smp_valid = v; smp_data = W'(x); phase_ctl = ctl; pkt_start = pk;
        model_step();
    endtask

    // symbol pattern value: alternating or run-length pattern
    function automatic int sym(input int i, input int pat, input int amp);
        bit b;
        if (pat == 0) b = i[0];
        else b = ((i % 7) < 4);
        return b ? amp : -amp;
    endfunction

    task automatic packet(input int off, input int amp, input int pat, input bit slow,
                          input int n_acq, input int n_ref, input int n_hold, input int drift);
        slow_only = slow;
        cyc(0, 0, 0, 1);
        for (int i = 0; i < n_acq; i++)
            cyc(1, off + sym(i, pat, amp) + $urandom_range(6) - 3, 0, 0);
        note = " R5";
        cyc(1, off + amp, 1, 0);          // rising edge on a sample cycle
        for (int i = 0; i < n_ref; i++) begin
            if (i == 0) note = " R5";
            cyc((i % 5) != 4, off + sym(i, pat, amp) + $urandom_range(4) - 2, 1, 0);
        end
        cyc(1, off - amp, 0, 0);          // falling edge on a sample cycle
        for (int i = 0; i < n_hold; i++)
            cyc(1, off + (i * drift) / 8 + sym(i, pat, amp), 0, 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset strobe", int'(bit_valid), 0);
        chk("R1 reset threshold", $signed(thr_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset strobe", int'(bit_valid), 0);
        chk("R1 after reset threshold", $signed(thr_out), 0);

        // R6: positive offset, alternating pattern, medium then slow
        packet(300, 400, 0, 1'b0, 20, 24, 30, 5);
        // R7: same stimulus in slow-only mode
        packet(300, 400, 0, 1'b1, 20, 24, 30, 5);
        // negative offset, run-length pattern, both modes
        packet(-517, 350, 1, 1'b0, 25, 30, 40, -3);
        packet(-517, 350, 1, 1'b1, 25, 30, 40, -3);

        // R10: second rising edge while holding reseeds from frozen extremes
        note = " R10";
        cyc(1, 900, 1, 0);
        for (int i = 0; i < 10; i++) begin
            note = " R10";
            cyc(1, 800 + sym(i, 0, 200), 1, 0);
        end
        cyc(1, 0, 0, 0);

        // R3: first sample is the largest value, min not yet updated
        slow_only = 1'b0;
        cyc(1, 123, 0, 1);                // sample in pkt_start cycle only sliced
        note = " R3";
        cyc(1, 2047, 0, 0);
        note = " R3";
        cyc(1, 0, 0, 0);
        note = " R3";
        cyc(1, -1, 0, 0);
        // R4: floor rounding of odd negative sum
        cyc(0, 0, 0, 1);
        cyc(1, -3, 0, 0);
        cyc(1, 0, 0, 0);
        note = " R4 floor";
        cyc(1, -1, 0, 0);
        cyc(1, -2, 0, 0);
        // R3: pkt_start wins over a rising edge in the same cycle
        cyc(1, 50, 1, 1);
        note = " R3 priority";
        cyc(1, 40, 1, 0);
        cyc(1, -40, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule